// File: doc/BRIEF.md
# Low-Side Fault Protection Controller

This block guards the three low-side switches of a three-phase bridge. It takes already-digitised comparator flags for overcurrent, short circuit and control-supply undervoltage. Each flag must persist for its own number of clock cycles before it counts as a fault. When a current fault qualifies, every low-side gate is masked and the active-low fault line is pulled down for a fixed pulse. When the pulse ends, each phase is re-armed on its own, and only after its command input has been seen at the OFF level. An undervoltage fault also masks the gates. It holds the fault line low for as long as the undervoltage lasts, instead of for a fixed time.

The controller is a four-state machine. ST_ARMED is normal operation, with gates following commands. ST_TRIP_PULSE is the timed current-fault pulse. ST_UV_HOLD is the level fault for undervoltage. ST_REARM waits for per-phase OFF commands. The named transitions are:
- trip: ST_ARMED, ST_REARM or ST_UV_HOLD go to ST_TRIP_PULSE on a qualified current fault.
- uv_enter: ST_ARMED or ST_REARM go to ST_UV_HOLD on qualified undervoltage.
- pulse_to_uv: ST_TRIP_PULSE goes to ST_UV_HOLD when the pulse ends while undervoltage is qualified.
- pulse_done: ST_TRIP_PULSE goes to ST_REARM.
- uv_clear: ST_UV_HOLD goes to ST_REARM.
- rearmed: ST_REARM goes to ST_ARMED once every phase has been released.

All times are parameters in clock cycles. The fault output models an open-drain driver: 0 means the pin is pulled low, and 1 means it is released.

Top module: `lsf_lowside_prot`

## Requirements
- R1: A clock edge at which the overcurrent flag has been sampled high on OC_FILT consecutive edges qualifies a current fault. Any shorter run causes no trip.
- R2: A clock edge at which the short-circuit flag has been sampled high on SC_FILT consecutive edges qualifies a current fault. Any shorter run causes no trip.
- R3: The undervoltage flag qualifies after UV_FILT consecutive high samples. fault_n then stays 0 while the flag stays high. The controller leaves the undervoltage hold at the first edge that samples the flag low.
- R4: From the edge that qualifies a current fault, lo_gate_en is all zero and fault_n is 0. While fault_n is 0, every bit of lo_gate_en is 0.
- R5: A current-fault pulse keeps fault_n at 0 for exactly FO_PULSE cycles. Further current flags during the pulse do not lengthen it.
- R6: After a fault ends, phase i stays masked until an edge samples lo_cmd_n[i] high (OFF). Phases are released independently, and the controller returns to normal once all phases are released.
- R7: If undervoltage is qualified when a current-fault pulse ends, fault_n stays 0 and the gates stay masked until undervoltage clears. Re-arming then follows R6.
- R8: Command encoding: lo_cmd_n[i] = 0 requests ON and 1 requests OFF. With no fault and no mask, lo_gate_en equals ~lo_cmd_n in the same cycle.
- R9: During and right after reset, fault_n is 1 and no phase is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_flag | input | 1 | Digitised overcurrent comparator flag |
| sc_flag | input | 1 | Digitised short-circuit comparator flag |
| uv_flag | input | 1 | Digitised control-supply undervoltage flag |
| lo_cmd_n | input | NPH | Low-side commands, 0 = ON, 1 = OFF |
| lo_gate_en | output | NPH | Masked low-side gate enables, 1 = drive gate |
| fault_n | output | 1 | Open-drain fault line: 0 = pull low, 1 = released |

## Verification
On every cycle, the assertions check four things: gates are blanked whenever the fault line is active, a pulse never starts without a qualified current flag, the pulse length is exact, and no gate can rise except after an OFF command sample. The undervoltage hold is also tied to the flag's sampled level. The bench scenarios show the rest: the exact filter thresholds for each flag, the independent per-phase release order after a trip, a retrigger during a pulse that does not extend it, and undervoltage that outlasts a pulse. A behavioural reference model compares both outputs on every clock.

// File: rtl/lsf_pkg.sv
`timescale 1ns/1ps
package lsf_pkg;
    typedef enum logic [1:0] {
        ST_ARMED      = 2'd0,
        ST_TRIP_PULSE = 2'd1,
        ST_REARM      = 2'd2,
        ST_UV_HOLD    = 2'd3
    } lsf_state_e;
endpackage

// File: rtl/lsf_persist.sv
`timescale 1ns/1ps
// Qualifies a flag once it has been sampled high on LIMIT consecutive edges
// (the current sample included).
module lsf_persist #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic qual
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!flag) begin
            run_cnt <= '0;
        end else if (run_cnt != TOP) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign qual = flag && (run_cnt == TOP);
endmodule

// File: rtl/lsf_pulse_timer.sv
`timescale 1ns/1ps
// Down-counter for the fault pulse; done when it reaches zero.
module lsf_pulse_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] START = CW'(LEN - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= START;
        end else if (run && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);
endmodule

// File: rtl/lsf_rearm_mask.sv
`timescale 1ns/1ps
// Per-phase gate mask: set on all phases together, cleared per phase on OFF.
module lsf_rearm_mask #(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_all,
    input  logic           rearm,
    input  logic [NPH-1:0] cmd_off,
    output logic [NPH-1:0] blk
);
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                blk[p] <= 1'b0;
            end else if (set_all) begin
                blk[p] <= 1'b1;
            end else if (rearm && cmd_off[p]) begin
                blk[p] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lsf_lowside_prot.sv
`timescale 1ns/1ps
module lsf_lowside_prot
    import lsf_pkg::*;
#(
    parameter int NPH      = 3,
    parameter int OC_FILT  = 500,
    parameter int SC_FILT  = 100,
    parameter int UV_FILT  = 500,
    parameter int FO_PULSE = 90000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           oc_flag,
    input  logic           sc_flag,
    input  logic           uv_flag,
    input  logic [NPH-1:0] lo_cmd_n,
    output logic [NPH-1:0] lo_gate_en,
    output logic           fault_n
);
    lsf_state_e state, state_nx;

    logic oc_q, sc_q, uv_q, cur_q;
    logic tmr_done, tmr_load, tmr_run;
    logic set_all, rearm_en, all_clear;
    logic [NPH-1:0] blk;

    lsf_persist #(.LIMIT(OC_FILT)) u_oc_filt (
        .clk(clk), .rst_n(rst_n), .flag(oc_flag), .qual(oc_q));
    lsf_persist #(.LIMIT(SC_FILT)) u_sc_filt (
        .clk(clk), .rst_n(rst_n), .flag(sc_flag), .qual(sc_q));
    lsf_persist #(.LIMIT(UV_FILT)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .flag(uv_flag), .qual(uv_q));

    assign cur_q = oc_q || sc_q;

    lsf_pulse_timer #(.LEN(FO_PULSE)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .done(tmr_done));

    lsf_rearm_mask #(.NPH(NPH)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_all(set_all), .rearm(rearm_en),
        .cmd_off(lo_cmd_n), .blk(blk));

    // a phase counts as released if it is unmasked or its OFF is sampled now
    assign all_clear = ((blk & ~lo_cmd_n) == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: begin
                if (cur_q)     state_nx = ST_TRIP_PULSE;   // trip
                else if (uv_q) state_nx = ST_UV_HOLD;      // uv_enter
            end
            ST_TRIP_PULSE: begin
                if (tmr_done) begin
                    if (uv_q) state_nx = ST_UV_HOLD;       // pulse_to_uv
                    else      state_nx = ST_REARM;         // pulse_done
                end
            end
            ST_UV_HOLD: begin
                if (cur_q)      state_nx = ST_TRIP_PULSE;  // trip
                else if (!uv_q) state_nx = ST_REARM;       // uv_clear
            end
            ST_REARM: begin
                if (cur_q)          state_nx = ST_TRIP_PULSE;  // trip
                else if (uv_q)      state_nx = ST_UV_HOLD;     // uv_enter
                else if (all_clear) state_nx = ST_ARMED;       // rearmed
            end
        endcase
    end

    // outputs and controls
    always_comb begin
        fault_n  = 1'b1;
        rearm_en = 1'b0;
        tmr_run  = 1'b0;
        unique case (state)
            ST_ARMED:      ;
            ST_TRIP_PULSE: begin fault_n = 1'b0; tmr_run = 1'b1; end
            ST_UV_HOLD:    fault_n = 1'b0;
            ST_REARM:      rearm_en = 1'b1;
        endcase
        tmr_load = (state_nx == ST_TRIP_PULSE) && (state != ST_TRIP_PULSE);
        set_all  = (state_nx == ST_TRIP_PULSE) || (state_nx == ST_UV_HOLD);
    end

    assign lo_gate_en = ~lo_cmd_n & ~blk;
endmodule

// File: rtl/lsf_prot_checker.sv
`timescale 1ns/1ps
module lsf_prot_checker
    import lsf_pkg::*;
#(
    parameter int NPH      = 3,
    parameter int OC_FILT  = 500,
    parameter int SC_FILT  = 100,
    parameter int FO_PULSE = 90000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           oc_flag,
    input logic           sc_flag,
    input logic           uv_flag,
    input logic [NPH-1:0] lo_cmd_n,
    input logic [NPH-1:0] lo_gate_en,
    input logic           fault_n,
    input lsf_state_e     state
);
    int oc_run, sc_run, pulse_age;
    logic trip_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_run    <= 0;
            sc_run    <= 0;
            pulse_age <= 0;
            trip_ok   <= 1'b0;
        end else begin
            oc_run    <= oc_flag ? oc_run + 1 : 0;
            sc_run    <= sc_flag ? sc_run + 1 : 0;
            pulse_age <= (state == ST_TRIP_PULSE) ? pulse_age + 1 : 0;
            trip_ok   <= (oc_flag && (oc_run + 1 >= OC_FILT)) ||
                         (sc_flag && (sc_run + 1 >= SC_FILT));
        end
    end

    // R4: an active fault line always coincides with blanked gates
    a_r4_fault_blanks_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (lo_gate_en == '0));

    // R1 / R2: a pulse starts only on a qualified current flag
    a_r1_r2_trip_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP_PULSE && $past(state) != ST_TRIP_PULSE) |-> trip_ok);

    // R5: the pulse never exceeds its length ...
    a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP_PULSE) |-> (pulse_age < FO_PULSE));

    // R5: ... and never ends early
    a_r5_pulse_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TRIP_PULSE && state != ST_TRIP_PULSE) |->
        ($past(pulse_age) == FO_PULSE - 1));

    // R3: the undervoltage hold exists only on a high flag sample
    a_r3_uv_hold_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UV_HOLD) |-> $past(uv_flag));

    // R7: while undervoltage persists the fault line stays active
    a_r7_uv_keeps_fault: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_UV_HOLD && $past(uv_flag)) |-> !fault_n);

    // R6: a gate can only turn on after its command was sampled OFF
    for (genvar p = 0; p < NPH; p++) begin : g_r6
        a_r6_release_after_off: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo_gate_en[p]) |-> $past(lo_cmd_n[p]));
    end
endmodule

bind lsf_lowside_prot lsf_prot_checker #(
    .NPH(NPH), .OC_FILT(OC_FILT), .SC_FILT(SC_FILT), .FO_PULSE(FO_PULSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .sc_flag(sc_flag),
    .uv_flag(uv_flag), .lo_cmd_n(lo_cmd_n), .lo_gate_en(lo_gate_en),
    .fault_n(fault_n), .state(state)
);

// File: tb/tb_lsf_lowside_prot.sv
`timescale 1ns/1ps
module tb_lsf_lowside_prot;
    localparam int NPH = 3;
    localparam int OCF = 10;
    localparam int SCF = 4;
    localparam int UVF = 8;
    localparam int FOP = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0, sc = 1'b0, uv = 1'b0;
    logic [NPH-1:0] cmd_n = '1;
    logic [NPH-1:0] gate_en;
    logic fault_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lsf_lowside_prot #(
        .NPH(NPH), .OC_FILT(OCF), .SC_FILT(SCF), .UV_FILT(UVF), .FO_PULSE(FOP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc), .sc_flag(sc), .uv_flag(uv),
        .lo_cmd_n(cmd_n), .lo_gate_en(gate_en), .fault_n(fault_n)
    );

    // behavioural reference: 0 normal, 1 pulse, 2 waiting for OFF, 3 uv hold
    int m_mode = 0, m_left = 0, r_oc = 0, r_sc = 0, r_uv = 0;
    bit [NPH-1:0] m_mask = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_mask = '0; r_oc = 0; r_sc = 0; r_uv = 0;
        end else begin
            bit cur, low;
            r_oc = oc ? r_oc + 1 : 0;
            r_sc = sc ? r_sc + 1 : 0;
            r_uv = uv ? r_uv + 1 : 0;
            cur = (r_oc >= OCF) || (r_sc >= SCF);
            low = (r_uv >= UVF);
            if (m_mode == 1) begin
                if (m_left == 0) m_mode = low ? 3 : 2;
                else m_left--;
            end else if (cur) begin
                m_mode = 1; m_left = FOP - 1; m_mask = '1;
            end else if (low && m_mode != 3) begin
                m_mode = 3; m_mask = '1;
            end else if (m_mode == 3 && !low) begin
                m_mode = 2;
            end else if (m_mode == 2) begin
                for (int p = 0; p < NPH; p++) if (cmd_n[p]) m_mask[p] = 1'b0;
                if (m_mask == '0) m_mode = 0;
            end
        end
    end

    always @(posedge clk) begin
        #3;
        if (!finished) begin
            logic [NPH-1:0] eg;
            logic ef;
            eg = ~cmd_n & ~m_mask;
            ef = !(m_mode == 1 || m_mode == 3);
            checks++;
            if (gate_en !== eg) begin
                errors++;
                $display("FAIL R4 model gate_en actual=%b expected=%b t=%0t", gate_en, eg, $time);
            end
            checks++;
            if (fault_n !== ef) begin
                errors++;
                $display("FAIL R5 model fault_n actual=%b expected=%b t=%0t", fault_n, ef, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt;
        step(3);
        chk(fault_n == 1'b1, "R9 fault idle in reset", fault_n, 1);
        cmd_n = 3'b000;
        step(1);
        chk(gate_en == 3'b111, "R9 no mask in reset", gate_en, 7);
        rst_n = 1'b1;
        step(2);
        chk(fault_n == 1'b1, "R9 fault idle after reset", fault_n, 1);

        // R8 encoding
        cmd_n = 3'b101;
        step(1);
        chk(gate_en == 3'b010, "R8 gate follows command", gate_en, 2);

        // R1 / R2 short runs
        oc = 1'b1; step(OCF - 1); oc = 1'b0; step(2);
        chk(fault_n == 1'b1, "R1 short overcurrent ignored", fault_n, 1);
        sc = 1'b1; step(SCF - 1); sc = 1'b0; step(2);
        chk(fault_n == 1'b1, "R2 short short-circuit ignored", fault_n, 1);

        // R1 exact trip, R4 blanking
        cmd_n = 3'b000;
        oc = 1'b1;
        step(OCF - 1);
        chk(fault_n == 1'b1, "R1 no trip one sample early", fault_n, 1);
        chk(gate_en == 3'b111, "R1 gates on before trip", gate_en, 7);
        step(1);
        chk(fault_n == 1'b0, "R4 fault on trip", fault_n, 0);
        chk(gate_en == 3'b000, "R4 gates off on trip", gate_en, 0);
        oc = 1'b0;
        step(3);
        sc = 1'b1; step(SCF + 2); sc = 1'b0;   // R5 retrigger must not extend
        cmd_n = 3'b010;
        cnt = SCF + 6;
        for (int i = 0; i < 1000; i++) begin
            step(1);
            if (fault_n) break;
            cnt++;
        end
        chk(cnt == FOP, "R5 pulse width", cnt, FOP);
        // R6 per-phase re-arm
        chk(gate_en == 3'b000, "R6 all blocked at pulse end", gate_en, 0);
        step(1);
        chk(gate_en == 3'b000, "R6 phases 0,2 still blocked while ON", gate_en, 0);
        cmd_n = 3'b011; step(1);
        cmd_n = 3'b010; step(1);
        chk(gate_en == 3'b001, "R6 phase 0 released alone", gate_en, 1);
        cmd_n = 3'b110; step(1);
        cmd_n = 3'b000; step(1);
        chk(gate_en == 3'b111, "R6 all phases released", gate_en, 7);

        // R2 exact trip
        sc = 1'b1;
        step(SCF);
        chk(fault_n == 1'b0, "R2 trip at threshold", fault_n, 0);
        sc = 1'b0;
        step(FOP);
        cmd_n = 3'b111; step(1);
        cmd_n = 3'b000; step(1);
        chk(gate_en == 3'b111 && fault_n, "R2 recovered", gate_en, 7);

        // R3 undervoltage as a level
        uv = 1'b1;
        step(UVF - 1);
        chk(fault_n == 1'b1, "R3 no uv fault early", fault_n, 1);
        step(1);
        chk(fault_n == 1'b0 && gate_en == 3'b000, "R3 uv fault", fault_n, 0);
        step(FOP + 20);
        chk(fault_n == 1'b0, "R3 uv fault held", fault_n, 0);
        uv = 1'b0;
        step(1);
        chk(fault_n == 1'b1, "R3 uv release", fault_n, 1);
        chk(gate_en == 3'b000, "R6 blocked after uv until OFF", gate_en, 0);
        cmd_n = 3'b111; step(1);
        cmd_n = 3'b000; step(1);
        chk(gate_en == 3'b111, "R6 released after uv", gate_en, 7);

        // R7 undervoltage outlasting the pulse
        oc = 1'b1; step(OCF); oc = 1'b0;
        chk(fault_n == 1'b0, "R7 trip", fault_n, 0);
        step(5);
        uv = 1'b1;
        step(FOP + 10);
        chk(fault_n == 1'b0 && gate_en == 3'b000, "R7 fault held past pulse", fault_n, 0);
        cmd_n = 3'b111; step(3);
        chk(fault_n == 1'b0, "R7 OFF does not clear during uv", fault_n, 0);
        uv = 1'b0;
        step(1);
        chk(fault_n == 1'b1, "R7 released when uv clears", fault_n, 1);
        step(1);
        cmd_n = 3'b000; step(1);
        chk(gate_en == 3'b111, "R7 gates back", gate_en, 7);

        step(3);
        finish_run();
    end
endmodule